// File: doc/BRIEF.md
# USART Bit-Clock Generator

This block produces the single-cycle enables that pace a serial transmitter and receiver. A 12-bit divisor sets the rate, and four clocking modes are supported. In the two asynchronous modes, the receive enable ticks at the oversampling rate. The transmit enable ticks at the bit rate, which is sixteen oversampling ticks in normal speed and eight in double speed. In the synchronous modes, a direction bit selects the source of the serial clock:

- **Master:** the block generates the clock internally and drives it out on the clock pin.
- **Slave:** the block takes the clock from the pin. The pin is synchronised and edge-detected before use.

In both synchronous modes, a polarity bit chooses which clock edge launches data and which edge samples it.

A single reloading down-counter feeds a divider chain of divide-by-2, then divide-by-4, then divide-by-2. Every mode taps one point of this chain. Double speed bypasses the last stage. The shift registers and framing logic that consume the enables sit outside this block.

Top module: `usart_clkgen`

## Requirements
- R1: While reset is held with a nonzero divisor, tx_en, rx_en and xck_out are all low.
- R2: In asynchronous mode (sync_mode=0, dbl_speed=0), tx_en pulses once every 16*(D+1) clock cycles, where D is baud_div.
- R3: In asynchronous mode with dbl_speed=1, the last divide-by-2 stage is bypassed, so tx_en pulses once every 8*(D+1) cycles.
- R4: In asynchronous mode, rx_en pulses once every D+1 cycles, and every tx_en pulse coincides with an rx_en pulse.
- R5: In master mode (sync_mode=1, clk_dir=1), xck_out is a square wave with a period of 2*(D+1) cycles. Outside master mode, xck_out stays low.
- R6: In master mode with clk_pol=0, tx_en is high in the cycle just before xck_out rises, and rx_en is high in the cycle just before it falls. With clk_pol=1 the two roles swap. In synchronous mode, tx_en and rx_en are never high together.
- R7: In slave mode (sync_mode=1, clk_dir=0), a level change on xck_in gives a one-cycle pulse. The pulse is visible in the cycle after the second rising clock edge that follows the change. With clk_pol=0, a rising pin edge pulses tx_en and a falling edge pulses rx_en; clk_pol=1 swaps them. The pin clock must be slower than a quarter of the system clock.
- R8: In asynchronous and master modes, activity on xck_in does not change the tx_en, rx_en or xck_out timing.
- R9: A change of baud_div reloads the counter at once. In asynchronous mode, the first rx_en after the change is observed D_new+1 cycles after the new value is applied, whatever the old count was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div | input | 12 | Baud divisor D; the prescaler divides by D+1 |
| sync_mode | input | 1 | 0 selects asynchronous operation, 1 selects synchronous |
| dbl_speed | input | 1 | Double speed; has an effect only in asynchronous mode |
| clk_dir | input | 1 | In synchronous mode: 1 is master (drive the pin), 0 is slave (use the pin) |
| clk_pol | input | 1 | Selects the launch edge and the sample edge of the serial clock |
| xck_in | input | 1 | External serial clock input from the pin |
| tx_en | output | 1 | Transmit bit-clock enable |
| rx_en | output | 1 | Receive clock enable |
| xck_out | output | 1 | Serial clock driven out in master mode |

## Verification
Every cycle, the assertions check the following:
- In synchronous mode, the two enables never coincide.
- Each asynchronous bit tick lands on an oversampling tick.
- The master clock only changes right after an enable.
- Slave and oversampling pulses last one cycle.
- The prescaler count never exceeds the divisor.

The bench scenarios cover what a per-cycle property cannot express:
- the exact periods for several divisors in each mode,
- the latency from a pin edge to its pulse,
- the immediate reload after a divisor write,
- the insensitivity to pin activity outside slave mode.

// File: rtl/usart_clkgen.sv
module usart_clkgen #(
  parameter int DIV_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             sync_mode,
  input  logic             dbl_speed,
  input  logic             clk_dir,
  input  logic             clk_pol,
  input  logic             xck_in,
  output logic             tx_en,
  output logic             rx_en,
  output logic             xck_out
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [DIV_W-1:0] cnt, div_q;
  logic             t2, t16;
  logic [1:0]       c4;
  logic [TOP:0]     xs;
  logic             xp;

  logic div_chg, tick_pre, tick_2, tick_8, tick_16;
  logic master, slave, lead, trail;

  assign div_chg  = baud_div != div_q;
  assign tick_pre = rst_n && (cnt == '0) && !div_chg;
  assign tick_2   = tick_pre && t2;
  assign tick_8   = tick_2 && (c4 == 2'd3);
  assign tick_16  = tick_8 && t16;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      div_q <= '0;
    end else begin
      div_q <= baud_div;
      if (div_chg || cnt == '0) cnt <= baud_div;
      else                      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t2  <= 1'b0;
      c4  <= '0;
      t16 <= 1'b0;
    end else begin
      if (tick_pre) t2  <= ~t2;
      if (tick_2)   c4  <= c4 + 1'b1;
      if (tick_8)   t16 <= ~t16;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xs <= '0;
      xp <= 1'b0;
    end else begin
      xs <= {xs[TOP-1:0], xck_in};
      xp <= xs[TOP];
    end
  end

  assign master = sync_mode && clk_dir;
  assign slave  = sync_mode && !clk_dir;
  assign lead   = master ? (tick_pre && !t2) : (xs[TOP] && !xp);
  assign trail  = master ? (tick_pre && t2)  : (!xs[TOP] && xp);

  assign tx_en   = !sync_mode ? (dbl_speed ? tick_8 : tick_16) : (clk_pol ? trail : lead);
  assign rx_en   = !sync_mode ? tick_pre : (clk_pol ? lead : trail);
  assign xck_out = master && t2;

  AST_SYNC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode |-> !(tx_en && rx_en)); // R6

  AST_ASYNC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_mode && tx_en) |-> rx_en); // R4

  AST_OVS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_mode && $past(!sync_mode) && $past(rx_en) && $past(baud_div) != '0) |-> !rx_en); // R4

  AST_XCK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (master && $past(master) && xck_out != $past(xck_out)) |-> $past(tx_en || rx_en)); // R5

  AST_SLAVE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (slave && $past(slave) && $stable(clk_pol) && $past(tx_en)) |-> !tx_en); // R7

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !div_chg |-> cnt <= baud_div); // R9

endmodule

// File: tb/usart_clkgen_test.sv
module usart_clkgen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] baud_div = 12'd5;
  logic        sync_mode = 1'b0, dbl_speed = 1'b0, clk_dir = 1'b0, clk_pol = 1'b0, xck_in = 1'b0;
  logic        tx_en, rx_en, xck_out;
  int tests = 0, fails = 0;
  bit done = 0;

  usart_clkgen uut (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .sync_mode(sync_mode),
    .dbl_speed(dbl_speed), .clk_dir(clk_dir), .clk_pol(clk_pol), .xck_in(xck_in),
    .tx_en(tx_en), .rx_en(rx_en), .xck_out(xck_out)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit ev(input int sel, input logic px);
    case (sel)
      0:       return tx_en;
      1:       return rx_en;
      default: return xck_out && !px;
    endcase
  endfunction

  task automatic gap(input int sel, output int g);
    logic px;
    bit   hit;
    int   n;
    px = xck_out;
    n = 0;
    do begin @(negedge clk); hit = ev(sel, px); px = xck_out; n++; end while (!hit && n < 5000);
    n = 0;
    do begin @(negedge clk); n++; hit = ev(sel, px); px = xck_out; end while (!hit && n < 5000);
    g = n;
  endtask

  task automatic setcfg(input logic s, input logic dir, input logic dbl, input logic pol, input int d);
    @(negedge clk);
    sync_mode = s; clk_dir = dir; dbl_speed = dbl; clk_pol = pol; baud_div = 12'(d);
    repeat (40) @(negedge clk);
  endtask

  task automatic pol_check(input logic pol, input string req);
    int bad;
    logic ptx, prx, pxk;
    bad = 0;
    setcfg(1'b1, 1'b1, 1'b0, pol, 2);
    ptx = tx_en; prx = rx_en; pxk = xck_out;
    repeat (200) begin
      @(negedge clk);
      if (ptx && !(pxk == pol && xck_out == !pol)) bad++;
      if (prx && !(pxk == !pol && xck_out == pol)) bad++;
      ptx = tx_en; prx = rx_en; pxk = xck_out;
    end
    chk(req, bad, 0);
  endtask

  task automatic slave_edge(input logic lvl, input int exp_tx, input string req);
    int tx_seen, rx_seen;
    @(negedge clk); xck_in = lvl;
    @(negedge clk); chk({req, " early"}, int'(tx_en || rx_en), 0);
    @(negedge clk); tx_seen = int'(tx_en); rx_seen = int'(rx_en);
    chk({req, " tx"}, tx_seen, exp_tx);
    chk({req, " rx"}, rx_seen, 1 - exp_tx);
    @(negedge clk); chk({req, " width"}, int'(tx_en || rx_en), 0);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int g, cnt;
    int ds[4] = '{0, 1, 3, 6};
    repeat (5) @(negedge clk);
    chk("R1 tx_en", int'(tx_en), 0);
    chk("R1 rx_en", int'(rx_en), 0);
    chk("R1 xck_out", int'(xck_out), 0);
    rst_n = 1'b1;

    foreach (ds[i]) begin
      setcfg(1'b0, 1'b0, 1'b0, 1'b0, ds[i]);
      gap(0, g); chk("R2 tx period", g, 16 * (ds[i] + 1));
      gap(0, g); chk("R2 tx period", g, 16 * (ds[i] + 1));
      gap(1, g); chk("R4 rx period", g, ds[i] + 1);
      cnt = 0;
      repeat (200) begin @(negedge clk); if (tx_en && !rx_en) cnt++; end
      chk("R4 tx on rx tick", cnt, 0);
      cnt = 0;
      repeat (50) begin @(negedge clk); if (xck_out) cnt++; end
      chk("R5 xck low async", cnt, 0);
      setcfg(1'b0, 1'b0, 1'b1, 1'b0, ds[i]);
      gap(0, g); chk("R3 dbl tx period", g, 8 * (ds[i] + 1));
      setcfg(1'b1, 1'b1, 1'b0, 1'b0, ds[i]);
      gap(2, g); chk("R5 xck period", g, 2 * (ds[i] + 1));
    end

    pol_check(1'b0, "R6 pol0");
    pol_check(1'b1, "R6 pol1");

    setcfg(1'b1, 1'b0, 1'b0, 1'b0, 3);
    cnt = 0;
    repeat (50) begin @(negedge clk); if (xck_out) cnt++; end
    chk("R5 xck low slave", cnt, 0);
    slave_edge(1'b1, 1, "R7 pol0 rise");
    slave_edge(1'b0, 0, "R7 pol0 fall");
    clk_pol = 1'b1;
    repeat (4) @(negedge clk);
    slave_edge(1'b1, 0, "R7 pol1 rise");
    slave_edge(1'b0, 1, "R7 pol1 fall");

    setcfg(1'b0, 1'b0, 1'b0, 1'b0, 1);
    fork
      repeat (300) begin @(negedge clk); xck_in = ~xck_in; end
      begin gap(0, g); chk("R8 async tx with pin noise", g, 32); end
    join
    setcfg(1'b1, 1'b1, 1'b0, 1'b0, 1);
    fork
      repeat (100) begin @(negedge clk); xck_in = ~xck_in; end
      begin gap(2, g); chk("R8 master xck with pin noise", g, 4); end
    join

    setcfg(1'b0, 1'b0, 1'b0, 1'b0, 9);
    gap(1, g);
    repeat (4) @(negedge clk);
    baud_div = 12'd2;
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!rx_en && cnt < 100);
    chk("R9 reload to 2", cnt, 3);
    baud_div = 12'd20;
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!rx_en && cnt < 100);
    chk("R9 reload to 20", cnt, 21);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule